// File: doc/BRIEF.md
# ADC conversion sequencer with result memory

This block is the digital controller that sits beside a 12-bit successive-approximation converter. It holds sixteen memory entries. Each entry pairs a control word with a result register. The control word names the input channel, the reference to use and whether the entry closes a sequence. When a trigger is accepted, the block walks the entries from a programmable start address. For each entry it presents the channel and reference to the converter with a one-cycle start pulse. It then waits for the converter's done pulse, stores the returned sample in that entry's result register and sets the entry's flag.

Four modes select how far a pass runs and whether it may run again:

- single: one entry per pass.
- sequence: consecutive entries until one whose end-of-sequence bit is set has been stored. Channels may differ from entry to entry, and the index wraps from the last entry to entry 0.
- repeated single and repeated sequence: each later trigger starts a fresh pass from the start address.

Triggers come from a software strobe or a timer line, chosen by a select input. Reading a result register clears its flag. Storing into an entry whose flag is still set raises a sticky overflow flag. An interrupt line reports any flag whose per-entry enable is set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset, busy, conv_start, irq, ovf and all bits of flags are 0.
- R2: In single mode (mode=0), an accepted trigger causes exactly one conversion. That conversion uses the channel and reference of the entry at start_addr. Its result is stored in that entry's result register, and flags bit start_addr is set.
- R3: In sequence mode (mode=1), the block converts consecutive entries, each with its own channel and reference, and stops after storing an entry whose control-word bit 6 (end of sequence) is 1. The entry after index 15 is index 0. The control word holds the channel in bits 3:0 and the reference in bits 5:4.
- R4: In repeat modes (mode=2 repeated single, mode=3 repeated sequence), every trigger accepted while idle starts a new pass from start_addr, without any change on enable.
- R5: In the non-repeat modes (0 and 1), once a pass completes, further triggers start nothing until enable goes low and then high again. A trigger is accepted only while enable is 1.
- R6: With trig_sel=0 only sw_start starts a pass. With trig_sel=1 only tmr_trig starts a pass.
- R7: busy goes high on the clock edge that accepts a trigger and goes low on the edge that takes the last conv_done of the pass. Triggers that arrive while busy is high are ignored.
- R8: A read request (rd_en with rd_addr) returns the stored result on rd_data on the next cycle and clears that entry's flag.
- R9: Storing a result into an entry whose flag is already set sets ovf. ovf stays set until ovf_clr is pulsed.
- R10: irq is 1, one cycle after the flags settle, exactly when some entry has both its flag and its int_en bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows triggers; a rising edge re-arms the non-repeat modes |
| mode | input | 2 | 0 single, 1 sequence, 2 repeated single, 3 repeated sequence |
| start_addr | input | 4 | First entry of a pass |
| trig_sel | input | 1 | 0 software strobe, 1 timer trigger |
| sw_start | input | 1 | Software start strobe |
| tmr_trig | input | 1 | Timer trigger pulse |
| ctl_we | input | 1 | Control word write strobe |
| ctl_addr | input | 4 | Control word write index |
| ctl_wdata | input | 7 | Control word: [3:0] channel, [5:4] reference, [6] end of sequence |
| rd_en | input | 1 | Result read request; clears the entry's flag |
| rd_addr | input | 4 | Result read index |
| rd_data | output | 12 | Result read data, valid the cycle after rd_en |
| int_en | input | 16 | Per-entry interrupt enables |
| flags | output | 16 | Per-entry result-ready flags |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A pass is in progress |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_ref | output | 2 | Reference select for the current conversion |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 12 | Converter sample, valid with conv_done |

## Verification
The bench runs a sequence that starts at entry 14 and closes on entry 0. This checks the index wrap: a design that fails to wrap would convert entry 16's alias or run past the end marker, and the channel log and stored results would show it. It pulses the unselected trigger source and re-triggers a finished single-mode pass. A design that ignores the select, or that never disarms, would start extra conversions that the bench counts. It strobes a start in the middle of a busy sequence, where a design that accepts it would restart or lengthen the pass. It also stores twice without a read and masks the flags through int_en, which catches a missing overflow flag or an interrupt that ignores its enables.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'd0,
    MODE_SEQ        = 2'd1,
    MODE_RPT_SINGLE = 2'd2,
    MODE_RPT_SEQ    = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  function automatic logic mode_repeats(input seq_mode_e m);
    return (m == MODE_RPT_SINGLE) || (m == MODE_RPT_SEQ);
  endfunction

  function automatic logic mode_walks(input seq_mode_e m);
    return (m == MODE_SEQ) || (m == MODE_RPT_SEQ);
  endfunction

endpackage

// File: rtl/adc_seq_ctlmem.sv
module adc_seq_ctlmem #(
  parameter int N_ENT = 16,
  parameter int CW    = 7,
  localparam int AW   = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);

  // Small distributed memory: synchronous write, asynchronous read.
  logic [CW-1:0] words [N_ENT];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int RES_W = 12,
  parameter int CH_W  = 4,
  parameter int REF_W = 2,
  localparam int AW   = $clog2(N_ENT),
  localparam int CW   = CH_W + REF_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_mode_e        mode,
  input  logic [AW-1:0]    start_addr,
  input  logic             enable,
  input  logic             trig_sel,
  input  logic             sw_start,
  input  logic             tmr_trig,
  input  logic [CW-1:0]    ctl_word,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic [AW-1:0]    idx,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic [REF_W-1:0] conv_ref,
  output logic             busy,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [RES_W-1:0] wr_data
);

  seq_state_e state;
  seq_mode_e  cur_mode;
  logic       cur_eos;
  logic       armed;
  logic       en_q;
  logic       trig;
  logic       accept;
  logic       last;
  logic       pass_end;

  assign trig     = trig_sel ? tmr_trig : sw_start;
  assign accept   = (state == ST_IDLE) && enable && trig && (mode_repeats(mode) || armed);
  assign last     = mode_walks(cur_mode) ? cur_eos : 1'b1;
  assign pass_end = (state == ST_WAIT) && conv_done && last;

  // Arming for the non-repeat modes: a rising enable arms, a finished pass disarms.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      armed <= 1'b0;
    end else begin
      en_q <= enable;
      if (enable && !en_q)                          armed <= 1'b1;
      else if (pass_end && !mode_repeats(cur_mode)) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_mode   <= MODE_SINGLE;
      cur_eos    <= 1'b0;
      idx        <= '0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      conv_ref   <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      conv_start <= 1'b0;
      wr_en      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_mode <= mode;
            idx      <= start_addr;
            busy     <= 1'b1;
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          conv_start <= 1'b1;
          conv_chan  <= ctl_word[CH_W-1:0];
          conv_ref   <= ctl_word[CH_W+REF_W-1:CH_W];
          cur_eos    <= ctl_word[CW-1];
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (conv_done) begin
            wr_en   <= 1'b1;
            wr_addr <= idx;
            wr_data <= conv_result;
            if (last) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              idx   <= (idx == AW'(N_ENT - 1)) ? '0 : idx + 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a start pulse is only issued inside a pass
  a_r7_start_in_pass: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  // R7: the converter start is a single-cycle pulse
  a_r7_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R7: busy only drops together with the final store of the pass
  a_r7_busy_ends_on_store: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> wr_en);

endmodule

// File: rtl/adc_seq_resmem.sv
module adc_seq_resmem #(
  parameter int N_ENT = 16,
  parameter int RES_W = 12,
  localparam int AW   = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [RES_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [RES_W-1:0] rd_data,
  input  logic [N_ENT-1:0] int_en,
  input  logic             ovf_clr,
  output logic [N_ENT-1:0] flags,
  output logic             ovf,
  output logic             irq
);

  // Block-RAM style: one write port, one registered read port, no reset.
  logic [RES_W-1:0] mem [N_ENT];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  logic hit_pending;
  assign hit_pending = wr_en && flags[wr_addr] && !(rd_en && (rd_addr == wr_addr));

  // One flag per entry; a store in the same cycle wins over a read clear.
  for (genvar i = 0; i < N_ENT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                   flags[i] <= 1'b0;
      else if (wr_en && (wr_addr == AW'(i)))     flags[i] <= 1'b1;
      else if (rd_en && (rd_addr == AW'(i)))     flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (ovf_clr)          ovf <= 1'b0;
      else if (hit_pending) ovf <= 1'b1;
      irq <= |(flags & int_en);
    end
  end

  // R2: a store always leaves its entry flagged
  a_r2_store_sets_flag: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> flags[$past(wr_addr)]);

  // R8: a read with no competing store clears the entry's flag
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(wr_en && (wr_addr == rd_addr))) |=> !flags[$past(rd_addr)]);

  // R9: overflow is sticky until cleared
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  // R10: no interrupt while every flag is clear
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> !irq);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int RES_W = 12,
  parameter int CH_W  = 4,
  parameter int REF_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic [1:0]               mode,
  input  logic [$clog2(N_ENT)-1:0] start_addr,
  input  logic                     trig_sel,
  input  logic                     sw_start,
  input  logic                     tmr_trig,
  input  logic                     ctl_we,
  input  logic [$clog2(N_ENT)-1:0] ctl_addr,
  input  logic [CH_W+REF_W:0]      ctl_wdata,
  input  logic                     rd_en,
  input  logic [$clog2(N_ENT)-1:0] rd_addr,
  output logic [RES_W-1:0]         rd_data,
  input  logic [N_ENT-1:0]         int_en,
  output logic [N_ENT-1:0]         flags,
  input  logic                     ovf_clr,
  output logic                     ovf,
  output logic                     irq,
  output logic                     busy,
  output logic                     conv_start,
  output logic [CH_W-1:0]          conv_chan,
  output logic [REF_W-1:0]         conv_ref,
  input  logic                     conv_done,
  input  logic [RES_W-1:0]         conv_result
);

  localparam int AW = $clog2(N_ENT);
  localparam int CW = CH_W + REF_W + 1;

  logic [AW-1:0]    idx;
  logic [CW-1:0]    ctl_word;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [RES_W-1:0] wr_data;

  adc_seq_ctlmem #(.N_ENT(N_ENT), .CW(CW)) u_ctl (
    .clk   (clk),
    .we    (ctl_we),
    .waddr (ctl_addr),
    .wdata (ctl_wdata),
    .raddr (idx),
    .rdata (ctl_word)
  );

  adc_seq_fsm #(.N_ENT(N_ENT), .RES_W(RES_W), .CH_W(CH_W), .REF_W(REF_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .mode        (seq_mode_e'(mode)),
    .start_addr  (start_addr),
    .enable      (enable),
    .trig_sel    (trig_sel),
    .sw_start    (sw_start),
    .tmr_trig    (tmr_trig),
    .ctl_word    (ctl_word),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .idx         (idx),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .conv_ref    (conv_ref),
    .busy        (busy),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );

  adc_seq_resmem #(.N_ENT(N_ENT), .RES_W(RES_W)) u_res (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .int_en  (int_en),
    .ovf_clr (ovf_clr),
    .flags   (flags),
    .ovf     (ovf),
    .irq     (irq)
  );

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable, trig_sel, sw_start, tmr_trig;
  logic [1:0]  mode;
  logic [3:0]  start_addr, ctl_addr, rd_addr;
  logic        ctl_we, rd_en, ovf_clr;
  logic [6:0]  ctl_wdata;
  logic [11:0] rd_data;
  logic [15:0] int_en, flags;
  logic        ovf, irq, busy, conv_start;
  logic [3:0]  conv_chan;
  logic [1:0]  conv_ref;
  logic        conv_done;
  logic [11:0] conv_result;

  always #4 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .start_addr(start_addr),
    .trig_sel(trig_sel), .sw_start(sw_start), .tmr_trig(tmr_trig),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .int_en(int_en), .flags(flags), .ovf_clr(ovf_clr), .ovf(ovf), .irq(irq),
    .busy(busy), .conv_start(conv_start), .conv_chan(conv_chan), .conv_ref(conv_ref),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  int checks = 0;
  int failures = 0;
  int nconv = 0;
  bit finished = 0;
  logic [3:0] log_chan [64];
  logic [1:0] log_ref  [64];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expect_res(input int ch, input int rf, input int n);
    return (2 << 10) | (ch << 6) | (rf << 4) | (n & 15);
  endfunction

  // Converter model: logs each request and answers three cycles later.
  initial begin
    logic [11:0] r;
    conv_done = 1'b0;
    conv_result = '0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        log_chan[nconv & 63] = conv_chan;
        log_ref[nconv & 63]  = conv_ref;
        r = 12'(expect_res(int'(conv_chan), int'(conv_ref), nconv));
        nconv++;
        repeat (3) @(negedge clk);
        conv_done = 1'b1;
        conv_result = r;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic wr_ctl(input int a, input int ch, input int rf, input int eos);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_addr = 4'(a);
    ctl_wdata = {1'(eos), 2'(rf), 4'(ch)};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_trig = 1'b1;
    @(negedge clk); tmr_trig = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1'b1; rd_addr = 4'(a);
    @(negedge clk); rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 conv_start", int'(conv_start), 0);
    chk("R1 flags", int'(flags), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ovf", int'(ovf), 0);
  endtask

  task automatic t_single();
    int n0, v;
    mode = 2'd0; start_addr = 4'd3; trig_sel = 1'b0; int_en = 16'h0008;
    rearm();
    n0 = nconv;
    pulse_sw();
    chk("R7 busy after accept", int'(busy), 1);
    while (!conv_done) @(negedge clk);
    @(negedge clk);
    chk("R7 busy low after last done", int'(busy), 0);
    wait_idle();
    chk("R2 one conversion", nconv - n0, 1);
    chk("R2 channel", int'(log_chan[n0 & 63]), 5);
    chk("R2 reference", int'(log_ref[n0 & 63]), 1);
    chk("R2 flag set", int'(flags), 16'h0008);
    chk("R10 irq with enabled flag", int'(irq), 1);
    rd(3, v);
    chk("R8 read data", v, expect_res(5, 1, n0));
    chk("R8 flag cleared", int'(flags), 0);
    @(negedge clk);
    chk("R10 irq drops", int'(irq), 0);
  endtask

  task automatic t_disarm();
    int n0, v;
    n0 = nconv;
    pulse_sw();
    repeat (20) @(negedge clk);
    chk("R5 no pass while disarmed", nconv - n0, 0);
    chk("R5 busy stays low", int'(busy), 0);
    rearm();
    pulse_sw();
    wait_idle();
    chk("R5 pass after rearm", nconv - n0, 1);
    rd(3, v);
  endtask

  task automatic t_trig_sel();
    int n0, v;
    trig_sel = 1'b1; mode = 2'd2;
    n0 = nconv;
    pulse_sw();
    repeat (20) @(negedge clk);
    chk("R6 sw ignored when timer selected", nconv - n0, 0);
    pulse_tmr();
    wait_idle();
    chk("R6 timer starts pass", nconv - n0, 1);
    pulse_tmr();
    wait_idle();
    chk("R4 repeated single reruns", nconv - n0, 2);
    chk("R9 ovf on double store", int'(ovf), 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R9 ovf cleared", int'(ovf), 0);
    rd(3, v);
    chk("R2 latest result kept", v, expect_res(5, 1, n0 + 1));
    trig_sel = 1'b0;
    n0 = nconv;
    pulse_tmr();
    repeat (20) @(negedge clk);
    chk("R6 timer ignored when sw selected", nconv - n0, 0);
  endtask

  task automatic t_seq();
    int n0, v;
    mode = 2'd1; start_addr = 4'd14; int_en = 16'h0000;
    rearm();
    n0 = nconv;
    pulse_sw();
    repeat (4) @(negedge clk);
    pulse_sw();
    wait_idle();
    chk("R7 mid-pass trigger ignored, R3 length", nconv - n0, 3);
    chk("R3 chan e14", int'(log_chan[n0 & 63]), 2);
    chk("R3 chan e15", int'(log_chan[(n0 + 1) & 63]), 9);
    chk("R3 chan e0 after wrap", int'(log_chan[(n0 + 2) & 63]), 7);
    chk("R3 ref e15", int'(log_ref[(n0 + 1) & 63]), 3);
    chk("R3 flags", int'(flags), 16'hC001);
    chk("R10 irq masked", int'(irq), 0);
    rd(14, v); chk("R3 result e14", v, expect_res(2, 0, n0));
    rd(15, v); chk("R3 result e15", v, expect_res(9, 3, n0 + 1));
    rd(0, v);  chk("R3 result e0", v, expect_res(7, 2, n0 + 2));
    chk("R8 all flags cleared", int'(flags), 0);
    chk("R9 no ovf after reads", int'(ovf), 0);
  endtask

  task automatic t_rpt_seq();
    int n0;
    mode = 2'd3;
    n0 = nconv;
    pulse_sw();
    wait_idle();
    pulse_sw();
    wait_idle();
    chk("R4 two repeated passes", nconv - n0, 6);
    chk("R4 second pass restarts", int'(log_chan[(n0 + 3) & 63]), 2);
    chk("R9 ovf from unread entries", int'(ovf), 1);
    chk("R10 irq masked by enables", int'(irq), 0);
    @(negedge clk); int_en = 16'h8000;
    repeat (2) @(negedge clk);
    chk("R10 irq on enabled flag", int'(irq), 1);
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; mode = 2'd0; start_addr = '0; trig_sel = 1'b0;
    sw_start = 1'b0; tmr_trig = 1'b0; ctl_we = 1'b0; ctl_addr = '0; ctl_wdata = '0;
    rd_en = 1'b0; rd_addr = '0; int_en = '0; ovf_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    wr_ctl(3, 5, 1, 0);
    wr_ctl(14, 2, 0, 0);
    wr_ctl(15, 9, 3, 0);
    wr_ctl(0, 7, 2, 1);
    t_single();
    t_disarm();
    t_trig_sel();
    t_seq();
    t_rpt_seq();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule